// File: doc/BRIEF.md
# System Command and Tick Status Port

This block sits on a small computer's I/O bus and provides two byte-wide registers. The first is a command port. Each value written to it performs exactly one action. The actions are:

- finishing the boot phase or requesting a reboot;
- choosing where the floppy controller's interrupt goes;
- setting or clearing the floppy terminal count;
- switching the external video, the disc motor or the beeper on or off.

Values outside the defined command range do nothing.

The second register is a status port. It reports:

- the current line flyback level;
- the floppy interrupt line;
- whether the display runs in its tall (32-line) mode;
- a 4-bit count of 300 Hz timer ticks.

The tick count stops at its maximum value and is cleared by reading the port. Software samples the flyback bit twice in a row. If the bit is set both times, software treats it as frame flyback.

The CPU interrupt outputs are derived from these sources. The standard interrupt request stays asserted while unread ticks are pending, or while the floppy interrupt is routed to it and active. The non-maskable request follows the floppy interrupt only when the floppy interrupt is routed there.

Top module: `sysctl_port`

## Requirements
- R1: Command 0 sets `boot_done`, which stays set until reset. Command 1 raises `reboot_pulse` for exactly the one cycle after the write edge.
- R2: Commands 2, 3 and 4 route the floppy interrupt to the non-maskable request, to the standard request, or to neither.
- R3: Command 5 sets `fdc_tc` and command 6 clears it.
- R4: Command 7 sets `ext_video_on` and command 8 clears it.
- R5: Command 9 sets `motor_on` and command 10 clears it.
- R6: Command 11 sets `beep_on` and command 12 clears it.
- R7: Writes of values 13 to 255 change no output.
- R8: After reset:
  - every control output is 0;
  - the floppy interrupt is routed to neither request;
  - the tick count is 0;
  - `int_req` and `nmi_req` are 0.
- R9: `stat_rdata` is combinational and is laid out as follows:
  - bit 7 reads 0;
  - bit 6 is `line_flyback`;
  - bit 5 is `fdc_irq_in`;
  - bit 4 is `tall_screen`;
  - bits 3..0 are the tick count.
- R10: Each `tick_300hz` pulse adds one to the tick count. The count holds at 15 once it reaches 15.
- R11: A cycle with `stat_rd` high clears the tick count. If a tick arrives in that same cycle, the count becomes 1.
- R12: `int_req` is high when the tick count is nonzero, or when the route is the standard request and `fdc_irq_in` is high. `nmi_req` is high only when the route is non-maskable and `fdc_irq_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the command port |
| ctl_wdata | input | 8 | Command value |
| stat_rd | input | 1 | Read strobe for the status port; clears the tick count |
| stat_rdata | output | 8 | Status byte |
| tick_300hz | input | 1 | One-cycle pulse per timer tick |
| line_flyback | input | 1 | Line flyback level |
| fdc_irq_in | input | 1 | Floppy controller interrupt level |
| tall_screen | input | 1 | Tall (32-line) display mode |
| boot_done | output | 1 | Boot phase finished |
| reboot_pulse | output | 1 | One-cycle reboot request |
| fdc_tc | output | 1 | Floppy terminal count |
| ext_video_on | output | 1 | External video enable |
| motor_on | output | 1 | Disc motor enable |
| beep_on | output | 1 | Beeper enable |
| nmi_req | output | 1 | Non-maskable interrupt request |
| int_req | output | 1 | Standard interrupt request |

## Verification
The results become visible at different times:

- **Command effects:** a command takes effect on the rising edge that samples `ctl_wr`. Its level outputs, and the one-cycle reboot pulse, are therefore visible from that edge until the next one.
- **Tick count:** tick and clear effects appear in the count one edge after the strobe.
- **Status byte and interrupt requests:** these are combinational, so a change on an input shows at once.

The bench drives strobes for one full cycle starting at a falling edge. It samples at the next falling edge, which is exactly one register stage later. Status fields are sampled inside the same half-cycle as the input change. The reboot pulse is checked both in its single high cycle and in the cycle after it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // Floppy interrupt destination
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_NMI  = 2'd1,
      ROUTE_INT  = 2'd2
   } fdc_route_e;

   // Command operation numbers (values below CMD_COUNT are defined)
   localparam logic [3:0] OP_BOOT_END  = 4'd0;
   localparam logic [3:0] OP_REBOOT    = 4'd1;
   localparam logic [3:0] OP_RT_NMI    = 4'd2;
   localparam logic [3:0] OP_RT_INT    = 4'd3;
   localparam logic [3:0] OP_RT_NONE   = 4'd4;
   localparam logic [3:0] OP_TC_SET    = 4'd5;
   localparam logic [3:0] OP_TC_CLR    = 4'd6;
   localparam logic [3:0] OP_VID_ON    = 4'd7;
   localparam logic [3:0] OP_VID_OFF   = 4'd8;
   localparam logic [3:0] OP_MOTOR_ON  = 4'd9;
   localparam logic [3:0] OP_MOTOR_OFF = 4'd10;
   localparam logic [3:0] OP_BEEP_ON   = 4'd11;
   localparam logic [3:0] OP_BEEP_OFF  = 4'd12;
   localparam int         CMD_COUNT    = 13;

endpackage

// File: rtl/sysctl_cmd_dec.sv
module sysctl_cmd_dec
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              boot_done,
   output logic              reboot_pulse,
   output logic              fdc_tc,
   output logic              video_on,
   output logic              motor_on,
   output logic              beep_on,
   output fdc_route_e        route
);

   localparam logic [DATA_W-1:0] LIMIT = DATA_W'(CMD_COUNT);

   logic       valid_cmd;
   logic [3:0] op;

   assign valid_cmd = wr && (wdata < LIMIT);
   assign op        = wdata[3:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_done    <= 1'b0;
         reboot_pulse <= 1'b0;
         fdc_tc       <= 1'b0;
         video_on     <= 1'b0;
         motor_on     <= 1'b0;
         beep_on      <= 1'b0;
         route        <= ROUTE_NONE;
      end else begin
         reboot_pulse <= 1'b0;
         if (valid_cmd) begin
            case (op)
               OP_BOOT_END:  boot_done    <= 1'b1;
               OP_REBOOT:    reboot_pulse <= 1'b1;
               OP_RT_NMI:    route        <= ROUTE_NMI;
               OP_RT_INT:    route        <= ROUTE_INT;
               OP_RT_NONE:   route        <= ROUTE_NONE;
               OP_TC_SET:    fdc_tc       <= 1'b1;
               OP_TC_CLR:    fdc_tc       <= 1'b0;
               OP_VID_ON:    video_on     <= 1'b1;
               OP_VID_OFF:   video_on     <= 1'b0;
               OP_MOTOR_ON:  motor_on     <= 1'b1;
               OP_MOTOR_OFF: motor_on     <= 1'b0;
               OP_BEEP_ON:   beep_on      <= 1'b1;
               OP_BEEP_OFF:  beep_on      <= 1'b0;
               default:      ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sysctl_tick_cnt.sv
module sysctl_tick_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] FULL = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         // a tick in the clearing cycle opens the next count
         count <= tick ? ONE : '0;
      end else if (tick && (count != FULL)) begin
         count <= count + ONE;
      end
   end

endmodule

// File: rtl/sysctl_status.sv
module sysctl_status
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic [CNT_W-1:0]  count,
   input  logic              tall,
   input  logic              fdc_irq,
   input  logic              line_fb,
   input  fdc_route_e        route,
   output logic [DATA_W-1:0] rdata,
   output logic              nmi_req,
   output logic              int_req
);

   localparam int TALL_BIT = CNT_W;
   localparam int FDC_BIT  = CNT_W + 1;
   localparam int LINE_BIT = CNT_W + 2;
   localparam int USED_W   = CNT_W + 3;

   logic [USED_W-1:0] used;

   assign used = {line_fb, fdc_irq, tall, count};

   generate
      if (DATA_W > USED_W) begin : g_pad
         assign rdata = {{(DATA_W-USED_W){1'b0}}, used};
      end else begin : g_exact
         assign rdata = used;
      end
   endgenerate

   assign nmi_req = (route == ROUTE_NMI) && fdc_irq;
   assign int_req = (count != '0) || ((route == ROUTE_INT) && fdc_irq);

endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              tick_300hz,
   input  logic              line_flyback,
   input  logic              fdc_irq_in,
   input  logic              tall_screen,
   output logic              boot_done,
   output logic              reboot_pulse,
   output logic              fdc_tc,
   output logic              ext_video_on,
   output logic              motor_on,
   output logic              beep_on,
   output logic              nmi_req,
   output logic              int_req
);

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("DATA_W must hold every command value");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (DATA_W < CNT_W + 3) begin : g_bad_fit
         $error("status byte too narrow for count and flags");
      end
   endgenerate

   fdc_route_e       route;
   logic [CNT_W-1:0] ticks;

   sysctl_cmd_dec #(.DATA_W(DATA_W)) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (ctl_wr),
      .wdata        (ctl_wdata),
      .boot_done    (boot_done),
      .reboot_pulse (reboot_pulse),
      .fdc_tc       (fdc_tc),
      .video_on     (ext_video_on),
      .motor_on     (motor_on),
      .beep_on      (beep_on),
      .route        (route)
   );

   sysctl_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_300hz),
      .clr   (stat_rd),
      .count (ticks)
   );

   sysctl_status #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stat (
      .count   (ticks),
      .tall    (tall_screen),
      .fdc_irq (fdc_irq_in),
      .line_fb (line_flyback),
      .route   (route),
      .rdata   (stat_rdata),
      .nmi_req (nmi_req),
      .int_req (int_req)
   );

endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic [DATA_W-1:0] ctl_wdata,
   input logic              stat_rd,
   input logic [DATA_W-1:0] stat_rdata,
   input logic              tick_300hz,
   input logic              fdc_irq_in,
   input logic              boot_done,
   input logic              reboot_pulse,
   input logic              fdc_tc,
   input logic              ext_video_on,
   input logic              motor_on,
   input logic              beep_on,
   input logic              nmi_req,
   input logic              int_req
);

   logic [CNT_W-1:0] cnt;
   assign cnt = stat_rdata[CNT_W-1:0];

   // R1
   reboot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |-> $past(ctl_wr && (ctl_wdata == DATA_W'(1))));

   // R5
   motor_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (ctl_wdata == DATA_W'(9))) |=> motor_on);

   // R7
   unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && (ctl_wdata >= DATA_W'(13))) |=>
         ($stable({boot_done, fdc_tc, ext_video_on, motor_on, beep_on}) && !reboot_pulse));

   // R10
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '1) && tick_300hz && !stat_rd) |=> (cnt == '1));

   // R11
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tick_300hz) |=> (cnt == '0));

   // R11
   rd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && tick_300hz) |=> (cnt == CNT_W'(1)));

   // R12
   nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> (fdc_irq_in && !int_req) || (fdc_irq_in && (cnt != '0)));

   // R12
   int_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> int_req);

endmodule

bind sysctl_port sysctl_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_wdata    (ctl_wdata),
   .stat_rd      (stat_rd),
   .stat_rdata   (stat_rdata),
   .tick_300hz   (tick_300hz),
   .fdc_irq_in   (fdc_irq_in),
   .boot_done    (boot_done),
   .reboot_pulse (reboot_pulse),
   .fdc_tc       (fdc_tc),
   .ext_video_on (ext_video_on),
   .motor_on     (motor_on),
   .beep_on      (beep_on),
   .nmi_req      (nmi_req),
   .int_req      (int_req)
);

// File: tb/sysctl_port_test.sv
module sysctl_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'd0;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       tick_300hz = 1'b0;
   logic       line_flyback = 1'b0;
   logic       fdc_irq_in = 1'b0;
   logic       tall_screen = 1'b0;
   logic       boot_done, reboot_pulse, fdc_tc, ext_video_on;
   logic       motor_on, beep_on, nmi_req, int_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sysctl_port uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_rd(stat_rd), .stat_rdata(stat_rdata), .tick_300hz(tick_300hz),
      .line_flyback(line_flyback), .fdc_irq_in(fdc_irq_in),
      .tall_screen(tall_screen), .boot_done(boot_done),
      .reboot_pulse(reboot_pulse), .fdc_tc(fdc_tc),
      .ext_video_on(ext_video_on), .motor_on(motor_on), .beep_on(beep_on),
      .nmi_req(nmi_req), .int_req(int_req)
   );

   // {code, expected video, motor, beep, tc}
   localparam int NVEC = 11;
   localparam logic [11:0] VEC [NVEC] = '{
      {8'd9,   4'b0100},   // R5 motor on
      {8'd11,  4'b0110},   // R6 beep on
      {8'd5,   4'b0111},   // R3 tc set
      {8'd7,   4'b1111},   // R4 video on
      {8'd13,  4'b1111},   // R7 ignored
      {8'd10,  4'b1011},   // R5 motor off
      {8'd255, 4'b1011},   // R7 ignored
      {8'd12,  4'b1001},   // R6 beep off
      {8'd6,   4'b1000},   // R3 tc clear
      {8'd8,   4'b0000},   // R4 video off
      {8'd200, 4'b0000}    // R7 ignored
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_code(input logic [7:0] c);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = c;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick_300hz = 1'b1;
      @(negedge clk);
      tick_300hz = 1'b0;
   endtask

   task automatic read_stat(input bit with_tick, output logic [7:0] val);
      @(negedge clk);
      stat_rd = 1'b1;
      tick_300hz = with_tick;
      #1 val = stat_rdata;
      @(negedge clk);
      stat_rd = 1'b0;
      tick_300hz = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8 reset state
      check("R8 controls", {boot_done, reboot_pulse, fdc_tc, ext_video_on, motor_on, beep_on}, 0);
      check("R8 status", stat_rdata, 0);
      check("R8 irq", {nmi_req, int_req}, 0);
      fdc_irq_in = 1'b1;
      #1 check("R8 route none", {nmi_req, int_req}, 0);
      fdc_irq_in = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         write_code(VEC[i][11:4]);
         check($sformatf("R3-6 vec %0d", i), {ext_video_on, motor_on, beep_on, fdc_tc}, VEC[i][3:0]);
      end
      // R7 ignored codes leave boot and reboot untouched
      check("R7 boot/reboot", {boot_done, reboot_pulse}, 0);

      // R1
      write_code(8'd0);
      check("R1 boot_done", {boot_done, reboot_pulse}, 2'b10);
      write_code(8'd1);
      check("R1 reboot high", reboot_pulse, 1);
      @(negedge clk);
      check("R1 reboot single", {boot_done, reboot_pulse}, 2'b10);

      // R9 status layout
      line_flyback = 1'b1; tall_screen = 1'b1;
      #1 check("R9 flyback+tall", stat_rdata, 8'h50);
      line_flyback = 1'b0; tall_screen = 1'b0; fdc_irq_in = 1'b1;
      #1 check("R9 fdc bit", stat_rdata, 8'h20);

      // R2 / R12 routing
      write_code(8'd2);
      check("R2 nmi route", {nmi_req, int_req}, 2'b10);
      write_code(8'd3);
      check("R2 int route", {nmi_req, int_req}, 2'b01);
      write_code(8'd4);
      check("R2 none route", {nmi_req, int_req}, 2'b00);
      fdc_irq_in = 1'b0;
      write_code(8'd3);
      check("R12 int needs fdc", {nmi_req, int_req}, 2'b00);

      // R10 counting and saturation
      repeat (3) pulse_tick();
      check("R10 count 3", stat_rdata[3:0], 3);
      check("R12 int from count", {nmi_req, int_req}, 2'b01);
      repeat (20) pulse_tick();
      check("R10 saturate", stat_rdata[3:0], 15);

      // R11 read clears
      read_stat(1'b0, v);
      check("R11 read value", v[3:0], 15);
      check("R11 cleared", stat_rdata[3:0], 0);
      check("R12 int drops", int_req, 0);
      read_stat(1'b1, v);
      check("R11 tick+read value", v[3:0], 0);
      check("R11 tick+read restart", stat_rdata[3:0], 1);
      read_stat(1'b0, v);
      check("R11 clear again", stat_rdata[3:0], 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule